// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a fixed-point arithmetic logic unit made of a chain of identical one-bit cells. A three-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or a signed less-than test on two operands. Subtraction uses the same ripple adder: every bit of the second operand is inverted and a carry of one enters the lowest cell. The less-than test runs that subtraction internally. Its answer goes to the lowest result bit only.

Besides the result, the unit reports a zero flag and a signed overflow flag. The zero flag supports equality tests through subtraction. The overflow flag follows the two's-complement sign rule. The arithmetic is combinational, and all three outputs are captured in a register stage that clears on a synchronous active-high reset, so each operation appears at the ports one clock after it is presented. Operand width is a parameter and defaults to 32 bits.

Top module: `bitslice_alu`

## Requirements
- R1: Code 3'b000 yields the bitwise AND of a and b.
- R2: Code 3'b001 yields the bitwise OR of a and b.
- R3: Code 3'b010 yields a + b, truncated to WIDTH bits.
- R4: Code 3'b110 yields a - b, truncated to WIDTH bits.
- R5: Code 3'b111 yields 1 in bit 0 when a < b as signed two's-complement values, else 0. All higher bits are 0. The answer stays correct when a - b overflows, for example when the most negative value is compared with a positive one.
- R6: The codes 3'b011, 3'b100 and 3'b101 yield a result of all zeros with overflow 0.
- R7: The zero output is 1 exactly when every result bit is 0.
- R8: For addition, overflow is 1 exactly when both operands have the same sign and the sum's sign differs from it.
- R9: For subtraction and for the less-than code, overflow is 1 exactly when the operands' signs differ and the sign of a - b differs from the sign of a. For AND and OR, overflow is 0.
- R10: Outputs are registered. Operands and code sampled at one rising clock edge appear on result, zero and overflow just after that edge. They stay unchanged until the next edge.
- R11: While rst is high at a rising edge, the outputs become result 0, zero 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Registered operation result |
| zero | output | 1 | Registered flag: result is all zeros |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
A fault inside the unit is always visible at the ports one clock after the faulty operation, because there is no state other than the output register. A broken carry link in one cell corrupts add, subtract and less-than results for some operand pairs. A wrong inversion control shows up as subtraction producing sums, and a missing overflow correction flips the less-than answer only when a - b overflows. Because of that, every operand pair at a narrow width is swept under every code, which includes all the sign-boundary cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [2:0] OPC_AND = 3'b000;
  localparam logic [2:0] OPC_OR  = 3'b001;
  localparam logic [2:0] OPC_ADD = 3'b010;
  localparam logic [2:0] OPC_SUB = 3'b110;
  localparam logic [2:0] OPC_SLT = 3'b111;

  // Output choice inside each one-bit cell
  typedef enum logic [2:0] {
    PICK_AND  = 3'd0,
    PICK_OR   = 3'd1,
    PICK_SUM  = 3'd2,
    PICK_LESS = 3'd3,
    PICK_NONE = 3'd4
  } cell_pick_e;

  typedef struct packed {
    logic       invert_b;  // invert b and carry one into cell 0
    logic       arith;     // overflow flag is meaningful
    cell_pick_e pick;
  } op_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [2:0] op_i,
  output op_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = '{invert_b: 1'b0, arith: 1'b0, pick: PICK_NONE};
    case (op_i)
      OPC_AND: ctrl_o.pick = PICK_AND;
      OPC_OR:  ctrl_o.pick = PICK_OR;
      OPC_ADD: ctrl_o = '{invert_b: 1'b0, arith: 1'b1, pick: PICK_SUM};
      OPC_SUB: ctrl_o = '{invert_b: 1'b1, arith: 1'b1, pick: PICK_SUM};
      OPC_SLT: ctrl_o = '{invert_b: 1'b1, arith: 1'b1, pick: PICK_LESS};
      default: ctrl_o = '{invert_b: 1'b0, arith: 1'b0, pick: PICK_NONE};
    endcase
  end

endmodule

// File: rtl/alu_cell.sv
module alu_cell
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       invert_b_i,
  input  logic       less_i,
  input  cell_pick_e pick_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);

  logic bx;

  assign bx     = b_i ^ invert_b_i;
  assign sum_o  = a_i ^ bx ^ cin_i;
  assign cout_o = (a_i & bx) | (a_i & cin_i) | (bx & cin_i);

  always_comb begin
    case (pick_i)
      PICK_AND:  res_o = a_i & b_i;
      PICK_OR:   res_o = a_i | b_i;
      PICK_SUM:  res_o = sum_o;
      PICK_LESS: res_o = less_i;
      default:   res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  op_ctrl_t         ctrl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic             ovf_raw;
  logic             less_flag;
  logic             b_msb_eff;

  assign carry[0] = ctrl_i.invert_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less_flag;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    alu_cell u_cell (
      .a_i        (a_i[i]),
      .b_i        (b_i[i]),
      .cin_i      (carry[i]),
      .invert_b_i (ctrl_i.invert_b),
      .less_i     (less_in),
      .pick_i     (ctrl_i.pick),
      .res_o      (res_o[i]),
      .sum_o      (sum[i]),
      .cout_o     (carry[i+1])
    );
  end

  // Sign rule on the effective second operand
  assign b_msb_eff = b_i[MSB] ^ ctrl_i.invert_b;
  assign ovf_raw   = (a_i[MSB] == b_msb_eff) && (sum[MSB] != a_i[MSB]);
  // True sign of a - b, corrected when the difference overflowed
  assign less_flag = sum[MSB] ^ ovf_raw;

  assign ovf_o  = ovf_raw & ctrl_i.arith;
  assign zero_o = ~|res_o;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  op_ctrl_t         ctrl;
  logic [WIDTH-1:0] res_c;
  logic             zero_c;
  logic             ovf_c;

  alu_op_decode u_dec (
    .op_i   (op),
    .ctrl_o (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .a_i    (a),
    .b_i    (b),
    .ctrl_i (ctrl),
    .res_o  (res_c),
    .zero_o (zero_c),
    .ovf_o  (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      zero     <= 1'b1;
      overflow <= 1'b0;
    end else begin
      result   <= res_c;
      zero     <= zero_c;
      overflow <= ovf_c;
    end
  end

endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (zero == (result == '0)));

  a_r1_and: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op) == 3'b000) |-> (result == ($past(a) & $past(b)) && !overflow));

  a_r2_or: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op) == 3'b001) |-> (result == ($past(a) | $past(b)) && !overflow));

  a_r3_add: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op) == 3'b010) |-> (result == WIDTH'($past(a) + $past(b))));

  a_r4_sub: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op) == 3'b110) |-> (result == WIDTH'($past(a) - $past(b))));

  a_r5_slt: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op) == 3'b111) |->
      (result == WIDTH'($signed($past(a)) < $signed($past(b)))));

  a_r6_unused: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ($past(op) inside {3'b011, 3'b100, 3'b101})) |-> (result == '0 && !overflow));

  a_r11_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && zero && !overflow));

endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op       (op),
  .a        (a),
  .b        (b),
  .result   (result),
  .zero     (zero),
  .overflow (overflow)
);

// File: tb/bitslice_alu_tb.sv
`timescale 1ns/1ps
module bitslice_alu_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op  = '0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         zero;
  logic         overflow;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bitslice_alu #(.WIDTH(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .a        (a),
    .b        (b),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  task automatic check(string tag, logic [W-1:0] er, logic ez, logic ev);
    n_chk++;
    if (result !== er || zero !== ez || overflow !== ev) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b v=%b, expected r=%h z=%b v=%b",
               tag, op, a, b, result, zero, overflow, er, ez, ev);
    end
  endtask

  task automatic expect_of(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                           output logic [W-1:0] er, output logic ev, output string tag);
    int sx = $signed(x);
    int sy = $signed(y);
    int s;
    int lo = -(1 << (W - 1));
    int hi = (1 << (W - 1)) - 1;
    er = '0; ev = 1'b0;
    case (o)
      3'b000: begin er = x & y; tag = "R1"; end
      3'b001: begin er = x | y; tag = "R2"; end
      3'b010: begin s = sx + sy; er = W'(s); ev = (s > hi || s < lo); tag = "R3/R8"; end
      3'b110: begin s = sx - sy; er = W'(s); ev = (s > hi || s < lo); tag = "R4/R9"; end
      3'b111: begin s = sx - sy; er = W'(sx < sy); ev = (s > hi || s < lo); tag = "R5/R9"; end
      default: tag = "R6";
    endcase
  endtask

  initial begin
    logic [W-1:0] er;
    logic         ev;
    string        tag;
    repeat (3) @(negedge clk);
    check("R11 reset", '0, 1'b1, 1'b0);
    rst = 1'b0;

    // Full sweep: every code, every operand pair (R7 on each zero flag)
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          @(negedge clk);
          op = 3'(o); a = W'(x); b = W'(y);
          @(negedge clk);
          expect_of(op, a, b, er, ev, tag);
          check({tag, " R7"}, er, (er == '0), ev);
        end
      end
    end

    // R10: output holds until the edge, then shows the new operation
    @(negedge clk);
    op = 3'b010; a = 4'h3; b = 4'h4;
    @(negedge clk);
    check("R10 add", 4'h7, 1'b0, 1'b0);
    op = 3'b000; a = 4'h5; b = 4'hA;
    #2;
    check("R10 hold before edge", 4'h7, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 update", 4'h0, 1'b1, 1'b0);

    // R5 extreme: most negative versus positive
    op = 3'b111; a = 4'h8; b = 4'h1;
    @(negedge clk);
    check("R5 minint<1", 4'h1, 1'b0, 1'b1);

    // R11 mid-run reset
    op = 3'b001; a = 4'hF; b = 4'h0; rst = 1'b1;
    @(negedge clk);
    check("R11 mid reset", '0, 1'b1, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", 4'hF, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule